// File: doc/BRIEF.md
# Start-of-Packet Timing Indicator

This block watches the transmit and receive sides of a byte- or nibble-wide media-independent data path. It produces one start-of-packet indicator for each direction, so that timestamp logic nearby can tell exactly when a frame begins. Each direction has its own enable. Two configuration inputs shape both indicators in the same way. The first picks the trigger: the first data unit of the frame, or the start-of-frame delimiter. The second picks the length: a level that lasts for the whole frame, or a pulse of a programmable number of cycles.

The transmit indicator passes through a fixed number of extra register stages. These model its constant offset from the line-side start of packet. A per-pin routing select places either indicator on any of a small set of general-purpose output pins.

Top module: `sop_indicator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, tx_sop, rx_sop and every pin_out bit are 0.
- R2: A direction whose enable is 0 produces no indication. Its indicator is 0 from the cycle after the enable is sampled low. The other direction is not affected.
- R3: With sfd_trigger=0, the receive indicator rises on the cycle after the first sample of a frame in which valid is 1, following a sample in which valid was 0.
- R4: With sfd_trigger=1, the trigger is the first delimiter in the frame. In byte mode (nibble_mode=0) the delimiter is data value 0xD5. In nibble mode it is a low nibble of 0x5 followed, in the next valid sample, by a low nibble of 0xD. The indicator rises on the cycle after the sample that completes the delimiter.
- R5: With sfd_trigger=1, a frame in which no delimiter appears before valid falls produces no indication.
- R6: With ncyc_mode=0, the indicator stays at 1 for as long as valid stays high. It drops on the cycle after the first sample in which valid is 0.
- R7: With ncyc_mode=1, the indicator is 1 for exactly ncyc_len cycles, and an ncyc_len of 0 counts as 1. If valid falls first, the indicator drops on the cycle after that sample, as in R6.
- R8: tx_sop follows the same rules as rx_sop applied to the transmit inputs, but arrives TX_LAT cycles later.
- R9: pin_out[i] is selected by the 2-bit field pin_sel[2i+1:2i]. Code 01 gives tx_sop, code 10 gives rx_sop, and codes 00 and 11 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit data valid |
| tx_data | input | 8 | Transmit data (low nibble in nibble mode) |
| rx_valid | input | 1 | Receive data valid |
| rx_data | input | 8 | Receive data (low nibble in nibble mode) |
| nibble_mode | input | 1 | 1: 4-bit data units, 0: bytes |
| tx_en | input | 1 | Transmit indicator enable |
| rx_en | input | 1 | Receive indicator enable |
| sfd_trigger | input | 1 | 1: trigger on delimiter, 0: trigger on first unit |
| ncyc_mode | input | 1 | 1: pulse of ncyc_len cycles, 0: whole frame |
| ncyc_len | input | CNT_W | Pulse length in cycles |
| pin_sel | input | 2*NUM_PINS | Per-pin routing code |
| tx_sop | output | 1 | Transmit start-of-packet indicator |
| rx_sop | output | 1 | Receive start-of-packet indicator |
| pin_out | output | NUM_PINS | General-purpose output pins |

## Verification
The bench builds the block with TX_LAT=2, CNT_W=4 and NUM_PINS=4. A two-stage transmit delay makes the transmit indicator lag the receive indicator visibly, even when both directions carry the same frame. The 4-bit count field makes a zero length, a short pulse and a pulse longer than the frame all easy to reach. Four pins allow every routing code to be present at the same time.

// File: rtl/sop_indicator.sv
module sop_indicator #(
  parameter int TX_LAT   = 2,
  parameter int CNT_W    = 4,
  parameter int NUM_PINS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_valid,
  input  logic [7:0]            tx_data,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  nibble_mode,
  input  logic                  tx_en,
  input  logic                  rx_en,
  input  logic                  sfd_trigger,
  input  logic                  ncyc_mode,
  input  logic [CNT_W-1:0]      ncyc_len,
  input  logic [2*NUM_PINS-1:0] pin_sel,
  output logic                  tx_sop,
  output logic                  rx_sop,
  output logic [NUM_PINS-1:0]   pin_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       vld, ena, sop_q;
  logic [7:0]       dat [2];
  logic [CNT_W-1:0] neff;

  assign vld    = {rx_valid, tx_valid};
  assign ena    = {rx_en, tx_en};
  assign dat[0] = tx_data;
  assign dat[1] = rx_data;
  assign neff   = (ncyc_len == '0) ? CNT_W'(1) : ncyc_len;

  for (genvar g = 0; g < 2; g++) begin : g_dir
    logic             prev_v, seen, hit, trig, keep;
    logic [3:0]       prev_nib;
    logic [CNT_W-1:0] cnt;

    assign hit  = !seen && vld[g] &&
                  (nibble_mode ? (prev_v && prev_nib == 4'h5 && dat[g][3:0] == 4'hD)
                               : (dat[g] == 8'hD5));
    assign trig = ena[g] && vld[g] && (sfd_trigger ? hit : !prev_v);
    assign keep = ena[g] && vld[g] && (!ncyc_mode || cnt < neff);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_v   <= 1'b0;
        prev_nib <= '0;
        seen     <= 1'b0;
        sop_q[g] <= 1'b0;
        cnt      <= '0;
      end else begin
        prev_v <= vld[g];
        if (vld[g]) prev_nib <= dat[g][3:0];
        if (!vld[g])  seen <= 1'b0;
        else if (hit) seen <= 1'b1;
        sop_q[g] <= trig || (sop_q[g] && keep);
        if (trig) cnt <= CNT_W'(1);
        else if (sop_q[g] && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end
    end

    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ena[g] |=> !sop_q[g]);
    a_r6_drop_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !vld[g] |=> !sop_q[g]);
    a_r3_rise_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sop_q[g]) |-> $past(vld[g]));
    a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (ncyc_mode && sop_q[g] && cnt >= neff) |=> !sop_q[g]);
  end

  assign rx_sop = sop_q[1];

  if (TX_LAT == 0) begin : g_nodly
    assign tx_sop = sop_q[0];
  end else begin : g_dly
    logic [TX_LAT-1:0] dly;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly <= '0;
      else        dly <= (dly << 1) | TX_LAT'(sop_q[0]);
    end
    assign tx_sop = dly[TX_LAT-1];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      case (pin_sel[2*p +: 2])
        2'b01:   pin_out[p] = tx_sop;
        2'b10:   pin_out[p] = rx_sop;
        default: pin_out[p] = 1'b0;
      endcase
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rx_sop && !tx_sop));
endmodule

// File: tb/sop_indicator_tb_top.sv
module sop_indicator_tb_top;
  localparam int TX_LAT = 2, CNT_W = 4, NUM_PINS = 4;

  logic clk = 0, rst_n = 0;
  logic tx_valid = 0, rx_valid = 0, nibble_mode = 0, tx_en = 0, rx_en = 0;
  logic sfd_trigger = 0, ncyc_mode = 0;
  logic [7:0] tx_data = 0, rx_data = 0;
  logic [CNT_W-1:0] ncyc_len = 0;
  logic [2*NUM_PINS-1:0] pin_sel = 0;
  logic tx_sop, rx_sop;
  logic [NUM_PINS-1:0] pin_out;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  sop_indicator #(.TX_LAT(TX_LAT), .CNT_W(CNT_W), .NUM_PINS(NUM_PINS)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .nibble_mode(nibble_mode),
    .tx_en(tx_en), .rx_en(rx_en), .sfd_trigger(sfd_trigger), .ncyc_mode(ncyc_mode),
    .ncyc_len(ncyc_len), .pin_sel(pin_sel), .tx_sop(tx_sop), .rx_sop(rx_sop),
    .pin_out(pin_out));

  int m_prev_v[2], m_prev_nib[2], m_seen[2], m_sop[2], m_cnt[2];
  int m_txq[TX_LAT];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_prev_v[d] = 0; m_prev_nib[d] = 0; m_seen[d] = 0; m_sop[d] = 0; m_cnt[d] = 0;
      end
      for (int k = 0; k < TX_LAT; k++) m_txq[k] = 0;
    end else begin
      for (int k = TX_LAT - 1; k > 0; k--) m_txq[k] = m_txq[k-1];
      m_txq[0] = m_sop[0];
      for (int d = 0; d < 2; d++) begin
        int v, en, dv, hit, start, lim;
        v  = (d == 0) ? int'(tx_valid) : int'(rx_valid);
        en = (d == 0) ? int'(tx_en) : int'(rx_en);
        dv = (d == 0) ? int'(tx_data) : int'(rx_data);
        if (nibble_mode)
          hit = (v && m_prev_v[d] && m_prev_nib[d] == 5 && (dv % 16) == 13 && !m_seen[d]);
        else
          hit = (v && dv == 8'hD5 && !m_seen[d]);
        start = en && v && (sfd_trigger ? hit : !m_prev_v[d]);
        lim = (ncyc_len == 0) ? 1 : int'(ncyc_len);
        if (start) begin
          m_sop[d] = 1; m_cnt[d] = 1;
        end else if (m_sop[d] && en && v && (!ncyc_mode || m_cnt[d] < lim)) begin
          m_cnt[d]++;
        end else m_sop[d] = 0;
        if (!v) m_seen[d] = 0; else if (hit) m_seen[d] = 1;
        if (v) m_prev_nib[d] = dv % 16;
        m_prev_v[d] = v;
      end
    end
  end

  function automatic bit pin_exp(int p);
    case (pin_sel[2*p +: 2])
      2'b01:   return bit'(m_txq[TX_LAT-1]);
      2'b10:   return bit'(m_sop[1]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(cur_req, rx_sop, m_sop[1], "rx_sop");
      chk((cur_req == "R1") ? "R1" : "R8", tx_sop, m_txq[TX_LAT-1], "tx_sop");
      for (int p = 0; p < NUM_PINS; p++)
        chk((cur_req == "R1") ? "R1" : "R9", pin_out[p], pin_exp(p), "pin_out");
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 counting bytes, 1 byte preamble+D5, 2 byte preamble without D5, 3 nibble preamble+D
  task automatic frame(int len, int kind);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      @(negedge clk);
      case (kind)
        1:       b = (i < 7) ? 8'h55 : (i == 7) ? 8'hD5 : 8'(8'h20 + i);
        2:       b = (i < 7) ? 8'h55 : 8'(8'h20 + i);
        3:       b = (i < 15) ? 8'h05 : (i == 15) ? 8'h0D : 8'(i % 4);
        default: b = 8'(8'h20 + i);
      endcase
      tx_valid = 1; rx_valid = 1; tx_data = b; rx_data = b;
    end
    @(negedge clk);
    tx_valid = 0; rx_valid = 0; tx_data = 0; rx_data = 0;
    idle(TX_LAT + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pin_sel = 8'b11_10_01_00;
    idle(3);
    cur_req = "R1";
    chk("R1", rx_sop, 0, "rx_sop in reset");
    chk("R1", tx_sop, 0, "tx_sop in reset");
    rst_n = 1;
    idle(2);

    cur_req = "R3"; tx_en = 1; rx_en = 1;
    frame(6, 0);
    cur_req = "R6";
    frame(1, 0);
    frame(9, 1);

    cur_req = "R2"; tx_en = 0;
    frame(5, 0);
    tx_en = 1; rx_en = 0;
    frame(5, 0);
    rx_en = 1;

    cur_req = "R4"; sfd_trigger = 1;
    frame(12, 1);
    pin_sel = 8'b10_01_10_01;
    cur_req = "R5";
    frame(12, 2);
    frame(6, 0);
    cur_req = "R4"; nibble_mode = 1;
    frame(22, 3);
    cur_req = "R5";
    frame(10, 3);
    nibble_mode = 0; sfd_trigger = 0;

    cur_req = "R7"; ncyc_mode = 1; ncyc_len = 3;
    frame(8, 0);
    ncyc_len = 0;
    frame(8, 0);
    ncyc_len = 10;
    frame(4, 0);
    ncyc_len = 4; sfd_trigger = 1;
    frame(14, 1);
    ncyc_mode = 0; sfd_trigger = 0;

    cur_req = "R9"; pin_sel = 8'b00_11_01_10;
    frame(5, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule